// File: doc/BRIEF.md
# Virtual Pending Interrupt Priority Selector

This block looks at a small bank of 64-bit virtual interrupt list entries and picks the pending entry with the highest priority. It then decides whether that entry may preempt the virtual CPU right now. Inputs are the entries, the interface enable, the two group enables, the virtual priority mask, the current running priority, a per-group priority mask and a flag that says a non-maskable interrupt is already active. Outputs are the selected index (or a "none" code), its priority, its non-maskable flag and a preempt-allowed signal.

Non-maskable entries get special treatment. They are not subject to the priority mask. They beat ordinary entries of equal priority. They may also preempt at a running priority equal to their own, provided no non-maskable interrupt is active. Selection and the preempt decision are combinational. All four results are registered, so they appear one clock after the inputs that produced them.

Top module: `virq_pick`

## Requirements
- R1: Each entry is 64 bits. Priority is bits 55:48, the non-maskable flag is bit 59, the group is bit 60 (0 = group 0, 1 = group 1), bit 61 is a hardware flag that does not affect selection, and the state is bits 63:62 (00 invalid, 01 pending, 10 active, 11 pending-and-active). Only state 01 makes an entry a candidate.
- R2: When both group enables are low, the outputs report no candidate: the index is all ones, the priority is 0xFF, the flag is 0 and preempt is 0. This holds whatever the entries contain.
- R3: Among candidates, the numerically lower priority wins. Among candidates of equal priority and equal non-maskable flag, the lowest index wins.
- R4: At equal priority, a non-maskable candidate displaces an ordinary one that was chosen earlier in the scan. An ordinary candidate never displaces a non-maskable one of equal priority.
- R5: An ordinary candidate with priority 0xFF is never selected. A non-maskable candidate with priority 0xFF can be selected.
- R6: An ordinary candidate whose priority is greater than or equal to the virtual priority mask cannot preempt. A non-maskable candidate ignores the priority mask.
- R7: Preempt is allowed when (candidate priority AND group mask) is less than (running priority AND group mask). The group mask used is the one for the candidate's group.
- R8: When the two masked priorities are equal, preempt is allowed only if the candidate is non-maskable and the active non-maskable flag is low.
- R9: Preempt is denied when the interface enable is low, or when the enable of the candidate's own group is low. In both cases the candidate is still reported.
- R10: The outputs are registers that update on the first rising clock edge after the inputs change. During reset they hold the no-candidate values of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_flat | input | 64*NUM_LR | List entries; entry i occupies bits 64*i+63 down to 64*i |
| vif_en | input | 1 | Overall virtual interface enable |
| grp0_en | input | 1 | Group 0 enable |
| grp1_en | input | 1 | Group 1 enable |
| vpmr | input | 8 | Virtual priority mask |
| run_prio | input | 8 | Current running priority |
| gmask0 | input | 8 | Priority group mask for group 0 |
| gmask1 | input | 8 | Priority group mask for group 1 |
| act_nmi | input | 1 | A non-maskable interrupt is currently active |
| sel_idx | output | IDXW | Selected entry index; all ones when there is no candidate |
| sel_prio | output | 8 | Priority of the selected entry; 0xFF when there is none |
| sel_nmi | output | 1 | Non-maskable flag of the selected entry |
| can_preempt | output | 1 | The selected entry may preempt |

## Verification
Every result of this block is due exactly one rising edge after its inputs change. The bench changes inputs 2 ns after a rising edge. It then reads the outputs 2 ns after the next rising edge, which is the first point where the new values are due. In one scenario the bench also reads the outputs 1 ns after the inputs change, before the edge, and expects the old values there. This confirms that the outputs are registered and not combinational.

// File: rtl/virq_pick_pkg.sv
package virq_pick_pkg;
  localparam int LR_W     = 64;
  localparam int PRIO_LSB = 48;
  localparam int PRIO_W   = 8;
  localparam int NMI_BIT  = 59;
  localparam int GRP_BIT  = 60;
  localparam int HW_BIT   = 61;
  localparam int ST_LSB   = 62;

  typedef enum logic [1:0] {
    ST_INVALID  = 2'b00,
    ST_PEND     = 2'b01,
    ST_ACT      = 2'b10,
    ST_PEND_ACT = 2'b11
  } lr_state_e;

  typedef struct packed {
    logic              cand;
    logic              nmi;
    logic              grp;
    logic [PRIO_W-1:0] prio;
  } lr_view_t;
endpackage

// File: rtl/virq_lr_decode.sv
module virq_lr_decode
  import virq_pick_pkg::*;
#(
  parameter int NUM_LR = 4
) (
  input  logic [LR_W*NUM_LR-1:0] lr_flat,
  input  logic                   scan_on,
  output lr_view_t [NUM_LR-1:0]  view
);
  logic [NUM_LR-1:0] unused_bits;

  for (genvar g = 0; g < NUM_LR; g++) begin : g_ent
    logic [LR_W-1:0] ent;
    lr_state_e       st;
    assign ent = lr_flat[g*LR_W +: LR_W];
    assign st  = lr_state_e'(ent[ST_LSB +: 2]);
    assign view[g] = {scan_on && (st == ST_PEND), ent[NMI_BIT], ent[GRP_BIT],
                      ent[PRIO_LSB +: PRIO_W]};
    // Hardware flag and low fields take no part in selection.
    assign unused_bits[g] = ^{ent[HW_BIT], ent[PRIO_LSB-1:0], ent[NMI_BIT-1:PRIO_LSB+PRIO_W]};
  end
endmodule

// File: rtl/virq_scan.sv
module virq_scan
  import virq_pick_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int IDXW   = $clog2(NUM_LR) + 1
) (
  input  lr_view_t [NUM_LR-1:0] view,
  output logic                  sel_valid,
  output logic [IDXW-1:0]       sel_idx,
  output logic [PRIO_W-1:0]     sel_prio,
  output logic                  sel_nmi,
  output logic                  sel_grp
);
  logic [NUM_LR:0]   bv;
  logic [NUM_LR:0]   bn;
  logic [NUM_LR:0]   bg;
  logic [PRIO_W-1:0] bp [NUM_LR+1];
  logic [IDXW-1:0]   bi [NUM_LR+1];

  assign bv[0] = 1'b0;
  assign bn[0] = 1'b0;
  assign bg[0] = 1'b0;
  assign bp[0] = '1;
  assign bi[0] = '1;

  // Ascending scan: replace only on strictly lower priority, or an NMI
  // winning a tie over an ordinary selection.
  for (genvar g = 0; g < NUM_LR; g++) begin : g_stage
    logic take;
    assign take = view[g].cand &&
                  ((view[g].prio < bp[g]) ||
                   ((view[g].prio == bp[g]) && view[g].nmi && !bn[g]));
    assign bv[g+1] = take | bv[g];
    assign bn[g+1] = take ? view[g].nmi  : bn[g];
    assign bg[g+1] = take ? view[g].grp  : bg[g];
    assign bp[g+1] = take ? view[g].prio : bp[g];
    assign bi[g+1] = take ? IDXW'(g)     : bi[g];
  end

  assign sel_valid = bv[NUM_LR];
  assign sel_idx   = bi[NUM_LR];
  assign sel_prio  = bp[NUM_LR];
  assign sel_nmi   = bn[NUM_LR];
  assign sel_grp   = bg[NUM_LR];
endmodule

// File: rtl/virq_preempt.sv
module virq_preempt
  import virq_pick_pkg::*;
(
  input  logic              sel_valid,
  input  logic [PRIO_W-1:0] prio,
  input  logic              nmi,
  input  logic              grp,
  input  logic              vif_en,
  input  logic              grp0_en,
  input  logic              grp1_en,
  input  logic [PRIO_W-1:0] vpmr,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic [PRIO_W-1:0] gmask0,
  input  logic [PRIO_W-1:0] gmask1,
  input  logic              act_nmi,
  output logic              allow
);
  logic [PRIO_W-1:0] gmask;
  logic [PRIO_W-1:0] mprio;
  logic [PRIO_W-1:0] mrun;
  logic              gen;
  logic              unmasked;
  logic              beats;

  always_comb begin
    gmask    = grp ? gmask1 : gmask0;
    gen      = grp ? grp1_en : grp0_en;
    mprio    = prio & gmask;
    mrun     = run_prio & gmask;
    unmasked = nmi || (prio < vpmr);
    beats    = (mprio < mrun) || ((mprio == mrun) && nmi && !act_nmi);
    allow    = sel_valid && vif_en && gen && unmasked && beats;
  end
endmodule

// File: rtl/virq_pick.sv
module virq_pick
  import virq_pick_pkg::*;
#(
  parameter int NUM_LR = 4,
  localparam int IDXW  = $clog2(NUM_LR) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LR_W*NUM_LR-1:0] lr_flat,
  input  logic                   vif_en,
  input  logic                   grp0_en,
  input  logic                   grp1_en,
  input  logic [PRIO_W-1:0]      vpmr,
  input  logic [PRIO_W-1:0]      run_prio,
  input  logic [PRIO_W-1:0]      gmask0,
  input  logic [PRIO_W-1:0]      gmask1,
  input  logic                   act_nmi,
  output logic [IDXW-1:0]        sel_idx,
  output logic [PRIO_W-1:0]      sel_prio,
  output logic                   sel_nmi,
  output logic                   can_preempt
);
  localparam logic [IDXW-1:0] IDX_NONE = '1;

  lr_view_t [NUM_LR-1:0] view;
  logic                  s_valid, s_nmi, s_grp, s_allow;
  logic [IDXW-1:0]       s_idx;
  logic [PRIO_W-1:0]     s_prio;
  logic [IDXW-1:0]       idx_d;
  logic [PRIO_W-1:0]     prio_d;
  logic                  nmi_d, pre_d;

  virq_lr_decode #(.NUM_LR(NUM_LR)) u_dec (
    .lr_flat (lr_flat),
    .scan_on (grp0_en | grp1_en),
    .view    (view)
  );

  virq_scan #(.NUM_LR(NUM_LR), .IDXW(IDXW)) u_scan (
    .view      (view),
    .sel_valid (s_valid),
    .sel_idx   (s_idx),
    .sel_prio  (s_prio),
    .sel_nmi   (s_nmi),
    .sel_grp   (s_grp)
  );

  virq_preempt u_pre (
    .sel_valid (s_valid),
    .prio      (s_prio),
    .nmi       (s_nmi),
    .grp       (s_grp),
    .vif_en    (vif_en),
    .grp0_en   (grp0_en),
    .grp1_en   (grp1_en),
    .vpmr      (vpmr),
    .run_prio  (run_prio),
    .gmask0    (gmask0),
    .gmask1    (gmask1),
    .act_nmi   (act_nmi),
    .allow     (s_allow)
  );

  always_comb begin
    idx_d  = s_valid ? s_idx  : IDX_NONE;
    prio_d = s_valid ? s_prio : '1;
    nmi_d  = s_valid && s_nmi;
    pre_d  = s_allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx     <= IDX_NONE;
      sel_prio    <= '1;
      sel_nmi     <= 1'b0;
      can_preempt <= 1'b0;
    end else begin
      sel_idx     <= idx_d;
      sel_prio    <= prio_d;
      sel_nmi     <= nmi_d;
      can_preempt <= pre_d;
    end
  end

  assert_pending_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> (lr_flat[ST_LSB + LR_W*int'(s_idx) +: 2] == 2'(ST_PEND)));

  assert_groups_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp0_en && !grp1_en) |=> (sel_idx == IDX_NONE && sel_prio == 8'hFF && !can_preempt));

  assert_no_ff_ordinary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_idx != IDX_NONE && !sel_nmi) |-> (sel_prio != 8'hFF));

  assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (can_preempt && !sel_nmi) |-> (sel_prio < $past(vpmr)));

  assert_preempt_has_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    can_preempt |-> (sel_idx != IDX_NONE));

  assert_vif_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vif_en |=> !can_preempt);
endmodule

// File: tb/virq_pick_tb.sv
module virq_pick_tb;
  localparam int NLR  = 4;
  localparam int IDXW = $clog2(NLR) + 1;
  localparam logic [IDXW-1:0] NONE = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] lr [NLR];
  logic [64*NLR-1:0] lr_flat;
  logic vif_en, grp0_en, grp1_en, act_nmi;
  logic [7:0] vpmr, run_prio, gmask0, gmask1;
  logic [IDXW-1:0] sel_idx;
  logic [7:0] sel_prio;
  logic sel_nmi, can_preempt;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < NLR; i++) lr_flat[i*64 +: 64] = lr[i];

  virq_pick #(.NUM_LR(NLR)) u_dut (
    .clk(clk), .rst_n(rst_n), .lr_flat(lr_flat), .vif_en(vif_en),
    .grp0_en(grp0_en), .grp1_en(grp1_en), .vpmr(vpmr), .run_prio(run_prio),
    .gmask0(gmask0), .gmask1(gmask1), .act_nmi(act_nmi),
    .sel_idx(sel_idx), .sel_prio(sel_prio), .sel_nmi(sel_nmi),
    .can_preempt(can_preempt)
  );

  function automatic logic [63:0] mk(logic [1:0] st, logic grp, logic nmi, logic [7:0] p);
    logic [63:0] v = '0;
    v[63:62] = st; v[60] = grp; v[59] = nmi; v[55:48] = p;
    return v;
  endfunction

  task automatic chk(string tag, logic [IDXW-1:0] ei, logic [7:0] ep, logic en, logic epre);
    total++;
    if (sel_idx !== ei || sel_prio !== ep || sel_nmi !== en || can_preempt !== epre) begin
      bad++;
      $display("FAIL %s: got idx=%0d prio=%h nmi=%0b pre=%0b expected idx=%0d prio=%h nmi=%0b pre=%0b",
               tag, sel_idx, sel_prio, sel_nmi, can_preempt, ei, ep, en, epre);
    end
  endtask

  task automatic defaults();
    vif_en = 1; grp0_en = 1; grp1_en = 1; act_nmi = 0;
    vpmr = 8'hFF; run_prio = 8'hFF; gmask0 = 8'hFF; gmask1 = 8'hFF;
    for (int i = 0; i < NLR; i++) lr[i] = '0;
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  task automatic t_reset_R10();
    chk("R10 reset", NONE, 8'hFF, 0, 0);
    rst_n = 1; settle(); settle();
    lr[0] = mk(2'b01, 0, 0, 8'h22);
    #1 chk("R10 before edge", NONE, 8'hFF, 0, 0);
    settle();
    chk("R10 after edge", 0, 8'h22, 0, 1);
  endtask

  task automatic t_states_R1();
    defaults();
    lr[0] = mk(2'b10, 0, 0, 8'h10); lr[1] = mk(2'b11, 0, 0, 8'h05);
    lr[2] = mk(2'b00, 0, 0, 8'h01); lr[3] = mk(2'b01, 1, 0, 8'h20);
    lr[3][61] = 1'b1;
    settle(); chk("R1 only pending", 3, 8'h20, 0, 1);
    lr[3] = mk(2'b11, 1, 0, 8'h20);
    settle(); chk("R1 none pending", NONE, 8'hFF, 0, 0);
  endtask

  task automatic t_order_R3();
    defaults();
    lr[0] = mk(2'b01, 0, 0, 8'h40); lr[1] = mk(2'b01, 0, 0, 8'h30);
    lr[2] = mk(2'b01, 1, 0, 8'h30); lr[3] = mk(2'b01, 0, 0, 8'h50);
    settle(); chk("R3 lowest first", 1, 8'h30, 0, 1);
  endtask

  task automatic t_tie_R4();
    defaults();
    lr[0] = mk(2'b01, 0, 0, 8'h30); lr[1] = mk(2'b01, 0, 0, 8'h30);
    lr[2] = mk(2'b01, 0, 1, 8'h30); lr[3] = mk(2'b01, 0, 1, 8'h30);
    settle(); chk("R4 nmi displaces", 2, 8'h30, 1, 1);
    lr[0] = mk(2'b01, 0, 1, 8'h30); lr[1] = mk(2'b01, 0, 0, 8'h30);
    lr[2] = '0; lr[3] = '0;
    settle(); chk("R4 ordinary keeps out", 0, 8'h30, 1, 1);
    lr[1] = mk(2'b01, 0, 0, 8'h20);
    settle(); chk("R4 lower still wins", 1, 8'h20, 0, 1);
  endtask

  task automatic t_ff_R5();
    defaults();
    lr[0] = mk(2'b01, 0, 0, 8'hFF);
    settle(); chk("R5 ordinary FF", NONE, 8'hFF, 0, 0);
    lr[1] = mk(2'b01, 0, 1, 8'hFF);
    settle(); chk("R5 nmi FF", 1, 8'hFF, 1, 1);
  endtask

  task automatic t_mask_R6();
    defaults(); vpmr = 8'h40;
    lr[0] = mk(2'b01, 0, 0, 8'h40);
    settle(); chk("R6 equal to mask", 0, 8'h40, 0, 0);
    lr[0] = mk(2'b01, 0, 0, 8'h3F);
    settle(); chk("R6 below mask", 0, 8'h3F, 0, 1);
    lr[0] = mk(2'b01, 0, 1, 8'h40);
    settle(); chk("R6 nmi ignores mask", 0, 8'h40, 1, 1);
  endtask

  task automatic t_run_R7();
    defaults(); run_prio = 8'h40; gmask0 = 8'hF0;
    lr[0] = mk(2'b01, 0, 0, 8'h3F);
    settle(); chk("R7 masked lower", 0, 8'h3F, 0, 1);
    lr[0] = mk(2'b01, 0, 0, 8'h45);
    settle(); chk("R7 masked equal", 0, 8'h45, 0, 0);
    run_prio = 8'h46; lr[0] = mk(2'b01, 1, 0, 8'h45);
    settle(); chk("R7 group1 mask", 0, 8'h45, 0, 1);
    gmask1 = 8'hF0;
    settle(); chk("R7 group1 coarse", 0, 8'h45, 0, 0);
  endtask

  task automatic t_eq_R8();
    defaults(); run_prio = 8'h40;
    lr[0] = mk(2'b01, 0, 1, 8'h40);
    settle(); chk("R8 nmi equal", 0, 8'h40, 1, 1);
    act_nmi = 1;
    settle(); chk("R8 nmi already active", 0, 8'h40, 1, 0);
    act_nmi = 0; gmask0 = 8'hF0; lr[0] = mk(2'b01, 0, 1, 8'h47);
    settle(); chk("R8 nmi masked equal", 0, 8'h47, 1, 1);
  endtask

  task automatic t_en_R9_R2();
    defaults();
    lr[0] = mk(2'b01, 1, 0, 8'h10);
    grp1_en = 0;
    settle(); chk("R9 group off", 0, 8'h10, 0, 0);
    grp1_en = 1; vif_en = 0;
    settle(); chk("R9 vif off", 0, 8'h10, 0, 0);
    vif_en = 1; grp0_en = 0; grp1_en = 0; lr[1] = mk(2'b01, 0, 1, 8'h00);
    settle(); chk("R2 both off", NONE, 8'hFF, 0, 0);
    grp0_en = 1;
    settle(); chk("R2 back on", 1, 8'h00, 1, 1);
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    defaults();
    #23;
    t_reset_R10();
    t_states_R1();
    t_order_R3();
    t_tie_R4();
    t_ff_R5();
    t_mask_R6();
    t_run_R7();
    t_eq_R8();
    t_en_R9_R2();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule